// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Combining Unit

This unit serves many thread processors that perform fetch-and-add on a small set of shared base registers. Each cycle, every request port may present an increment and pick one base register. The unit merges all requests that target the same base into one multi-operand operation. Each requester gets back the base value plus the increments of all requesters ranked ahead of it. The base then takes the grand total. Requests to different bases combine independently in the same cycle.

Requesters on one base are ranked by ascending port number. The running sums come from a logarithmic-depth parallel-prefix adder per base. Responses are registered, so they appear one clock after the request. A serial controller can load any base register. If that load falls in the same cycle as requests, the load applies first and the requests combine against the loaded value. The controller can also read any base at any time through a combinational read port.

When every increment is 1, the returned values are distinct consecutive slots starting at the old base. This is the property that array compaction relies on.

Top module: `psu_top`

## Requirements
- R1: A lone request to base B with increment X returns, one cycle later, the value B held before, and B then holds B+X.
- R2: Several requests to the same base in one cycle are ranked by ascending port index. The lowest port gets the original base, and every other port gets the original base plus the sum of the increments of all lower-indexed ports on that base.
- R3: After a combined operation the base holds the original value plus the sum of every increment that targeted it in that cycle.
- R4: Requests selecting different bases (select code b picks base register b, 0 to 3) in the same cycle combine separately, and no base sees another base's increments.
- R5: rspValid of port p is high in the cycle after reqValid of port p was sampled high, and low otherwise. Port p's data occupies bits p*32+31 down to p*32 of reqInc and rspOld, and its select occupies bits 2p+1 down to 2p of reqSel.
- R6: All sums are 32-bit unsigned and wrap modulo 2^32.
- R7: With every increment equal to 1, k requests on one base return the k consecutive values old, old+1, …, old+k-1 in port order.
- R8: A base load in the same cycle as requests to that base applies first, and the requests combine against the loaded value.
- R9: After reset every base reads 0 and no response is valid.
- R10: A base with neither a load nor a request in a cycle keeps its value, and baseRdData always shows the current value of the base chosen by baseRdSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 8 | Request strobe, one bit per port |
| reqInc | input | 256 | Increment per port, 32 bits each |
| reqSel | input | 16 | Base select per port, 2 bits each |
| rspValid | output | 8 | Response strobe, one bit per port |
| rspOld | output | 256 | Returned prefix value per port, 32 bits each |
| baseWrEn | input | 1 | Load strobe from the serial controller |
| baseWrSel | input | 2 | Base register to load |
| baseWrData | input | 32 | Value to load |
| baseRdSel | input | 2 | Base register to read |
| baseRdData | output | 32 | Current value of the selected base |

## Verification
The assertions assume that the request and load inputs are stable around the sampling edge and carry known values, never X. They also assume that reset is held for at least one edge before any request. The bench changes every input only on the falling clock edge and holds reset over several rising edges. Its random traffic draws select codes only from the four valid bases and mixes loads in at a low rate, so that same-cycle load and request collisions still occur.

// File: rtl/psu_pkg.sv
`timescale 1ns/1ps
package psu_pkg;
  localparam int NUM_PORTS = 8;
  localparam int NUM_BASES = 4;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = $clog2(NUM_BASES);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_BASES-1:0]                loadHit;   // base is loaded this cycle
    logic [NUM_BASES-1:0][NUM_PORTS-1:0] member;    // port p joins base b
    logic [NUM_PORTS-1:0]                rspLoad;   // capture response for port p
  } psuStrobe_t;
endpackage

// File: rtl/psu_scan.sv
`timescale 1ns/1ps
// inclusive parallel-prefix sum, log2(LANES) adder levels
module psu_scan #(
  parameter int LANES = 8,
  parameter int WIDTH = 32
) (
  input  logic [LANES-1:0][WIDTH-1:0] din,
  output logic [LANES-1:0][WIDTH-1:0] incl
);
  localparam int LEVELS = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0][WIDTH-1:0] stage [LEVELS+1];

  always_comb begin
    stage[0] = din;
    for (int k = 0; k < LEVELS; k++) begin
      for (int i = 0; i < LANES; i++) begin
        if (i >= (1 << k)) stage[k+1][i] = stage[k][i] + stage[k][i - (1 << k)];
        else               stage[k+1][i] = stage[k][i];
      end
    end
  end

  assign incl = stage[LEVELS];
endmodule

// File: rtl/psu_ctrl.sv
`timescale 1ns/1ps
module psu_ctrl
  import psu_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0]              reqValid,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]   reqSel,
  input  logic                              baseWrEn,
  input  logic [SEL_W-1:0]                  baseWrSel,
  output psuStrobe_t                        strobe,
  output logic [NUM_PORTS-1:0]              rspValid
);
  always_comb begin
    strobe = '0;
    for (int b = 0; b < NUM_BASES; b++) begin
      strobe.loadHit[b] = baseWrEn && (baseWrSel == SEL_W'(b));
      for (int p = 0; p < NUM_PORTS; p++)
        strobe.member[b][p] = reqValid[p] && (reqSel[p] == SEL_W'(b));
    end
    strobe.rspLoad = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= '0;
    else       rspValid <= reqValid;
  end

  // R5: an idle request cycle leaves every response strobe low
  a_r5_idle_no_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqValid) |=> !(|rspValid));
endmodule

// File: rtl/psu_datapath.sv
`timescale 1ns/1ps
module psu_datapath
  import psu_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  psuStrobe_t                        strobe,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  reqInc,
  input  logic [DATA_W-1:0]                 loadData,
  input  logic [SEL_W-1:0]                  rdSel,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rspOld,
  output logic [DATA_W-1:0]                 rdData
);
  logic [NUM_BASES-1:0][DATA_W-1:0]                 baseReg;
  logic [NUM_BASES-1:0][DATA_W-1:0]                 startBase;
  logic [NUM_BASES-1:0][DATA_W-1:0]                 total;
  logic [NUM_BASES-1:0][NUM_PORTS-1:0][DATA_W-1:0]  masked;
  logic [NUM_BASES-1:0][NUM_PORTS-1:0][DATA_W-1:0]  inclSum;
  logic [NUM_PORTS-1:0][DATA_W-1:0]                 portResult;

  genvar b, p;
  generate
    for (b = 0; b < NUM_BASES; b++) begin : g_base
      // load applies ahead of the combine (R8)
      assign startBase[b] = strobe.loadHit[b] ? loadData : baseReg[b];

      for (p = 0; p < NUM_PORTS; p++) begin : g_mask
        assign masked[b][p] = strobe.member[b][p] ? reqInc[p] : '0;
      end

      psu_scan #(.LANES(NUM_PORTS), .WIDTH(DATA_W)) u_scan (
        .din  (masked[b]),
        .incl (inclSum[b])
      );

      assign total[b] = inclSum[b][NUM_PORTS-1];

      always_ff @(posedge clk) begin
        if (!rstN) baseReg[b] <= '0;
        else       baseReg[b] <= startBase[b] + total[b];
      end

      // R10: untouched base keeps its value
      a_r10_base_hold: assert property (@(posedge clk) disable iff (!rstN)
        (!(|strobe.member[b]) && !strobe.loadHit[b]) |=> $stable(baseReg[b]));

      // R8: a load with no requests lands exactly
      a_r8_load_only: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.loadHit[b] && !(|strobe.member[b])) |=> (baseReg[b] == $past(loadData)));

      for (p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam logic [NUM_PORTS-1:0] LOWER = NUM_PORTS'((1 << p) - 1);
        // R2: lowest-ranked member receives the unmodified start value
        a_r2_first_gets_base: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.member[b][p] && ((strobe.member[b] & LOWER) == '0))
          |=> (rspOld[p] == $past(startBase[b])));
        // R1, R3: a lone requester moves the base by exactly its increment
        a_r3_single_total: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.member[b][p] && ($countones(strobe.member[b]) == 1))
          |=> (baseReg[b] == $past(startBase[b]) + $past(reqInc[p])));
      end
    end
  endgenerate

  // select the exclusive prefix for each port from its own base
  always_comb begin
    for (int q = 0; q < NUM_PORTS; q++) begin
      portResult[q] = '0;
      for (int c = 0; c < NUM_BASES; c++) begin
        if (strobe.member[c][q])
          portResult[q] = startBase[c] + ((q == 0) ? '0 : inclSum[c][(q == 0) ? 0 : q-1]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspOld <= '0;
    else begin
      for (int q = 0; q < NUM_PORTS; q++)
        if (strobe.rspLoad[q]) rspOld[q] <= portResult[q];
    end
  end

  assign rdData = baseReg[rdSel];
endmodule

// File: rtl/psu_top.sv
`timescale 1ns/1ps
module psu_top
  import psu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [NUM_PORTS*DATA_W-1:0]   reqInc,
  input  logic [NUM_PORTS*SEL_W-1:0]    reqSel,
  output logic [NUM_PORTS-1:0]          rspValid,
  output logic [NUM_PORTS*DATA_W-1:0]   rspOld,
  input  logic                          baseWrEn,
  input  logic [SEL_W-1:0]              baseWrSel,
  input  logic [DATA_W-1:0]             baseWrData,
  input  logic [SEL_W-1:0]              baseRdSel,
  output logic [DATA_W-1:0]             baseRdData
);
  psuStrobe_t                       strobe;
  logic [NUM_PORTS-1:0][DATA_W-1:0] incVec;
  logic [NUM_PORTS-1:0][SEL_W-1:0]  selVec;
  logic [NUM_PORTS-1:0][DATA_W-1:0] oldVec;

  assign incVec = reqInc;
  assign selVec = reqSel;
  assign rspOld = oldVec;

  psu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSel    (selVec),
    .baseWrEn  (baseWrEn),
    .baseWrSel (baseWrSel),
    .strobe    (strobe),
    .rspValid  (rspValid)
  );

  psu_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqInc   (incVec),
    .loadData (baseWrData),
    .rdSel    (baseRdSel),
    .rspOld   (oldVec),
    .rdData   (baseRdData)
  );

  // R5: a response strobe never appears without a request the cycle before
  a_r5_rsp_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |-> (|$past(reqValid)));
endmodule

// File: tb/psu_top_tb.sv
`timescale 1ns/1ps
module psu_top_tb;
  localparam int NP = 8;
  localparam int NB = 4;
  localparam int DW = 32;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    reqValid = '0;
  logic [NP*DW-1:0] reqInc = '0;
  logic [NP*SW-1:0] reqSel = '0;
  logic [NP-1:0]    rspValid;
  logic [NP*DW-1:0] rspOld;
  logic             baseWrEn = 1'b0;
  logic [SW-1:0]    baseWrSel = '0;
  logic [DW-1:0]    baseWrData = '0;
  logic [SW-1:0]    baseRdSel = '0;
  logic [DW-1:0]    baseRdData;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] model [NB];
  logic          vIn   [NP];
  logic [DW-1:0] incIn [NP];
  logic [SW-1:0] selIn [NP];

  always #2 clk = ~clk;

  psu_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInc(reqInc), .reqSel(reqSel),
    .rspValid(rspValid), .rspOld(rspOld), .baseWrEn(baseWrEn), .baseWrSel(baseWrSel),
    .baseWrData(baseWrData), .baseRdSel(baseRdSel), .baseRdData(baseRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    for (int p = 0; p < NP; p++) begin vIn[p] = 1'b0; incIn[p] = '0; selIn[p] = '0; end
  endtask

  task automatic readBases(input string tag);
    for (int b = 0; b < NB; b++) begin
      baseRdSel = SW'(b);
      #0.1;
      check(baseRdData == model[b], tag, baseRdData, model[b]);
    end
  endtask

  // called at a falling edge; one request cycle, then checks after the rising edge
  task automatic runCycle(input string tag, input bit wrEn, input int wrSel, input logic [DW-1:0] wrData);
    logic [DW-1:0] acc [NB];
    logic [DW-1:0] expOld [NP];
    for (int b = 0; b < NB; b++) acc[b] = (wrEn && wrSel == b) ? wrData : model[b];
    for (int p = 0; p < NP; p++) begin
      expOld[p] = '0;
      if (vIn[p]) begin
        expOld[p] = acc[selIn[p]];
        acc[selIn[p]] = acc[selIn[p]] + incIn[p];
      end
    end
    for (int p = 0; p < NP; p++) begin
      reqValid[p] = vIn[p];
      reqInc[p*DW +: DW] = incIn[p];
      reqSel[p*SW +: SW] = selIn[p];
    end
    baseWrEn = wrEn; baseWrSel = SW'(wrSel); baseWrData = wrData;
    @(posedge clk);
    #1;
    reqValid = '0; baseWrEn = 1'b0;
    for (int b = 0; b < NB; b++) model[b] = acc[b];
    for (int p = 0; p < NP; p++) begin
      check(rspValid[p] == vIn[p], {tag, " R5 valid"}, 32'(rspValid[p]), 32'(vIn[p]));
      if (vIn[p]) check(rspOld[p*DW +: DW] == expOld[p], {tag, " data"}, rspOld[p*DW +: DW], expOld[p]);
    end
    readBases({tag, " base"});
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int b = 0; b < NB; b++) model[b] = '0;
    clearReq();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    check(rspValid == '0, "R9 no valid", 32'(rspValid), 0);
    readBases("R9 bases zero");

    // R1: lone request on base 1
    clearReq(); vIn[3] = 1; incIn[3] = 32'd7; selIn[3] = 2'd1;
    runCycle("R1 lone", 0, 0, 0);
    clearReq(); vIn[0] = 1; incIn[0] = 32'd5; selIn[0] = 2'd1;
    runCycle("R1 second", 0, 0, 0);

    // R10: idle cycle, nothing changes, no response
    clearReq();
    runCycle("R10 idle", 0, 0, 0);

    // R2 R3: all ports on base 0 with distinct increments
    clearReq();
    for (int p = 0; p < NP; p++) begin vIn[p] = 1; incIn[p] = 32'(p * 3 + 1); selIn[p] = 2'd0; end
    runCycle("R2 R3 all-on-one", 0, 0, 0);

    // R7: unit increments after loading 100 into base 2
    clearReq();
    runCycle("R8 load", 1, 2, 32'd100);
    for (int p = 0; p < NP; p++) begin vIn[p] = 1; incIn[p] = 32'd1; selIn[p] = 2'd2; end
    runCycle("R7 compaction", 0, 0, 0);
    // R7: sparse unit requests give gap-free slots
    clearReq();
    vIn[1] = 1; vIn[4] = 1; vIn[6] = 1;
    incIn[1] = 1; incIn[4] = 1; incIn[6] = 1;
    selIn[1] = 2; selIn[4] = 2; selIn[6] = 2;
    runCycle("R7 sparse", 0, 0, 0);

    // R6: wrap around 2^32
    clearReq();
    runCycle("R6 preload", 1, 3, 32'hFFFF_FFF0);
    for (int p = 0; p < 4; p++) begin vIn[p] = 1; incIn[p] = 32'h8; selIn[p] = 2'd3; end
    runCycle("R6 wrap", 0, 0, 0);

    // R8: load and requests on the same base in one cycle
    clearReq();
    vIn[2] = 1; incIn[2] = 32'd10; selIn[2] = 2'd1;
    vIn[5] = 1; incIn[5] = 32'd20; selIn[5] = 2'd1;
    runCycle("R8 load+req", 1, 1, 32'h1000);

    // R4: interleaved bases
    clearReq();
    for (int p = 0; p < NP; p++) begin vIn[p] = 1; incIn[p] = 32'(100 + p); selIn[p] = SW'(p % NB); end
    runCycle("R4 interleave", 0, 0, 0);

    // random mix: R2 R3 R4 R8
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NP; p++) begin
        vIn[p] = ($urandom % 3) != 0;
        incIn[p] = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 16);
        selIn[p] = SW'($urandom % NB);
      end
      runCycle("R2 R3 R4 random", ($urandom % 8) == 0, int'($urandom % NB), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule